// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps the time of day for a 12-hour clock. Seconds and minutes are each held as a pair of BCD digits: a units digit that rolls over after 9 feeds a tens digit that rolls over after 5. Each pair passes a single-cycle carry to the next stage when it rolls over from 59 to 00. Hours are held as a binary value running from 1 to 12 and leave the block as two BCD digits. A meridian flag marks the second half of the day and flips whenever the hour steps from 11 to 12.

In normal operation a one-cycle seconds enable, usually one pulse per second, drives the whole chain. When the set-mode select is high, the minute and hour stages stop listening to their carries. Each one then advances only on its own manual increment pulse, so time can be set one step at a time. The seconds stage keeps counting its enable in set mode, but its rollover is discarded. All state sits in one clock domain, and every carry is an enable rather than a derived clock.

Top module: `clock12_time_ctr`

## Requirements
- R1: While rst_ni is low, and at once when it falls, the outputs read 12:00 AM: hr_bcd_o = 5'h12, min_bcd_o = 7'h00, pm_o = 0. The hidden seconds count is also 00.
- R2: In normal mode (set_mode_i = 0), each clock cycle with sec_tick_i high advances the seconds by one. The 60th tick after second 00 changes min_bcd_o on the same edge, and ticks 1 to 59 leave it unchanged.
- R3: min_bcd_o = {tens[2:0], units[3:0]} in BCD. The units digit runs 0 to 9 and then carries into the tens digit. 59 rolls over to 00, and in normal mode that edge also advances the hour.
- R4: hr_bcd_o = {tens[0], units[3:0]} in BCD and follows the sequence 12, 1, 2, ..., 11, 12. It never reads 0 or a value above 12.
- R5: pm_o flips exactly when the hour steps from 11 to 12. This holds for a carry from the minutes and for a manual hour increment alike. No other hour step changes pm_o.
- R6: In set mode, minutes advance only on cycles with inc_m_i high and hours only on cycles with inc_h_i high. A seconds rollover changes neither.
- R7: In set mode, an inc_m_i pulse at minute 59 gives minute 00 and leaves hr_bcd_o and pm_o unchanged.
- R8: In normal mode, inc_m_i and inc_h_i have no effect on any output.
- R9: Every change takes effect on the rising clk_i edge at which its enable is sampled high. Outputs stay stable on every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle seconds enable |
| set_mode_i | input | 1 | 1 = set mode, manual increments drive minutes and hours |
| inc_m_i | input | 1 | Manual minute increment, used in set mode only |
| inc_h_i | input | 1 | Manual hour increment, used in set mode only |
| min_bcd_o | output | 7 | Minutes as BCD, tens in [6:4], units in [3:0] |
| hr_bcd_o | output | 5 | Hours as BCD, tens in [4], units in [3:0] |
| pm_o | output | 1 | 0 = AM, 1 = PM |

## Verification
The assertions assume that every input is synchronous to clk_i and settles before the rising edge. They also assume that set_mode_i is meant to be held, with no intent for it to drop in the same cycle as a manual increment. The stimulus changes inputs only on falling edges and changes set_mode_i only in cycles where neither increment is high. It holds each enable high for a counted number of cycles, which makes the expected time a matter of arithmetic. The manual-hour and seconds-carry paths each take the hour across 11 to 12 so that the meridian flip is seen on both routes.

// File: rtl/clock12_pkg.sv
package clock12_pkg;
  localparam int unsigned UNITS_MAX  = 9;
  localparam int unsigned TENS_MAX   = 5;
  localparam int unsigned HOUR_TOP   = 12;
  localparam int unsigned HOUR_W     = 4;
  localparam int unsigned MIN_W      = 7;
  localparam int unsigned HR_BCD_W   = 5;
  localparam int unsigned N_SIXTY    = 2;  // seconds, minutes

  function automatic logic [HR_BCD_W-1:0] hour_to_bcd(input logic [HOUR_W-1:0] h);
    if (h >= HOUR_W'(10)) hour_to_bcd = {1'b1, h - HOUR_W'(10)};
    else                  hour_to_bcd = {1'b0, h};
  endfunction
endpackage

// File: rtl/bcd_digit_ctr.sv
module bcd_digit_ctr #(
  parameter int unsigned MAX = 9,
  parameter int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic         wrap_o
);
  logic [W-1:0] q_q;

  assign wrap_o = en_i && (q_q == W'(MAX));
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= wrap_o ? '0 : q_q + W'(1);
  end

  a_r3_digit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q <= W'(MAX));
  a_r9_digit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_q));
  a_r3_digit_rollover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && q_q == W'(MAX)) |=> q_q == '0);
endmodule

// File: rtl/sixty_ctr.sv
module sixty_ctr
  import clock12_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [MIN_W-1:0] bcd_o,
  output logic             wrap_o
);
  logic [3:0] units;
  logic [2:0] tens;
  logic       units_wrap;

  bcd_digit_ctr #(.MAX(UNITS_MAX), .W(4)) u_units (
    .clk_i, .rst_ni, .en_i(en_i), .q_o(units), .wrap_o(units_wrap)
  );
  bcd_digit_ctr #(.MAX(TENS_MAX), .W(3)) u_tens (
    .clk_i, .rst_ni, .en_i(units_wrap), .q_o(tens), .wrap_o(wrap_o)
  );

  assign bcd_o = {tens, units};
endmodule

// File: rtl/hour_ctr.sv
module hour_ctr
  import clock12_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  output logic [HR_BCD_W-1:0] bcd_o,
  output logic                pm_o
);
  logic [HOUR_W-1:0] hour_q;
  logic              pm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hour_q <= HOUR_W'(HOUR_TOP);
      pm_q   <= 1'b0;
    end else if (en_i) begin
      hour_q <= (hour_q == HOUR_W'(HOUR_TOP)) ? HOUR_W'(1) : hour_q + HOUR_W'(1);
      if (hour_q == HOUR_W'(HOUR_TOP - 1)) pm_q <= ~pm_q;
    end
  end

  assign bcd_o = hour_to_bcd(hour_q);
  assign pm_o  = pm_q;

  a_r4_hour_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_q >= HOUR_W'(1) && hour_q <= HOUR_W'(HOUR_TOP));
  a_r4_after_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hour_q == HOUR_W'(HOUR_TOP)) |=> hour_q == HOUR_W'(1));
  a_r5_pm_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hour_q == HOUR_W'(HOUR_TOP - 1)) |=> pm_q != $past(pm_q));
  a_r5_pm_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && hour_q == HOUR_W'(HOUR_TOP - 1)) |=> $stable(pm_q));
endmodule

// File: rtl/clock12_time_ctr.sv
module clock12_time_ctr
  import clock12_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sec_tick_i,
  input  logic                set_mode_i,
  input  logic                inc_m_i,
  input  logic                inc_h_i,
  output logic [MIN_W-1:0]    min_bcd_o,
  output logic [HR_BCD_W-1:0] hr_bcd_o,
  output logic                pm_o
);
  logic [N_SIXTY-1:0]  stage_en;
  logic [N_SIXTY-1:0]  stage_wrap;
  logic [MIN_W-1:0]    stage_bcd [N_SIXTY];
  logic                hour_en;

  // stage 0 = seconds, stage 1 = minutes
  assign stage_en[0] = sec_tick_i;
  assign stage_en[1] = set_mode_i ? inc_m_i : stage_wrap[0];
  assign hour_en     = set_mode_i ? inc_h_i : stage_wrap[1];

  for (genvar s = 0; s < N_SIXTY; s++) begin : g_sixty
    sixty_ctr u_stage (
      .clk_i, .rst_ni,
      .en_i   (stage_en[s]),
      .bcd_o  (stage_bcd[s]),
      .wrap_o (stage_wrap[s])
    );
  end

  hour_ctr u_hours (
    .clk_i, .rst_ni, .en_i(hour_en), .bcd_o(hr_bcd_o), .pm_o(pm_o)
  );

  assign min_bcd_o = stage_bcd[1];

  a_r6_set_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mode_i && !inc_m_i) |=> $stable(min_bcd_o));
  a_r6_set_hr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mode_i && !inc_h_i) |=> $stable(hr_bcd_o) && $stable(pm_o));
  a_r8_norm_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_mode_i && !sec_tick_i) |=> $stable(min_bcd_o) && $stable(hr_bcd_o));
  a_r7_manual_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mode_i && inc_m_i && !inc_h_i && min_bcd_o == 7'h59)
      |=> min_bcd_o == 7'h00 && $stable(hr_bcd_o) && $stable(pm_o));
endmodule

// File: tb/sim_clock12_time_ctr.sv
module sim_clock12_time_ctr;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 20;

  typedef struct packed {
    logic [3:0]  req;
    logic        set;
    logic        sec;
    logic        im;
    logic        ih;
    logic [15:0] reps;
    logic [6:0]  min;
    logic [4:0]  hr;
    logic        pm;
  } step_t;

  // walked from reset (12:00:00 AM)
  localparam step_t STEPS [NSTEP] = '{
    '{4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'd59,  7'h00, 5'h12, 1'b0}, // R2 59 ticks, no carry
    '{4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1,   7'h01, 5'h12, 1'b0}, // R2 60th tick
    '{4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'd600, 7'h11, 5'h12, 1'b0}, // R3 units to tens
    '{4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 16'd5,   7'h11, 5'h12, 1'b0}, // R8 inc_m ignored
    '{4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 16'd3,   7'h11, 5'h12, 1'b0}, // R8 inc_h ignored
    '{4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 16'd48,  7'h59, 5'h12, 1'b0}, // R6 manual minutes
    '{4'd7, 1'b1, 1'b0, 1'b1, 1'b0, 16'd1,   7'h00, 5'h12, 1'b0}, // R7 wrap, no hour
    '{4'd6, 1'b1, 1'b1, 1'b0, 1'b0, 16'd120, 7'h00, 5'h12, 1'b0}, // R6 sec carry dropped
    '{4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1,   7'h00, 5'h01, 1'b0}, // R4 12 -> 1
    '{4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 16'd9,   7'h00, 5'h10, 1'b0}, // R4 10
    '{4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1,   7'h00, 5'h11, 1'b0}, // R4 11
    '{4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1,   7'h00, 5'h12, 1'b1}, // R5 manual to 12
    '{4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1,   7'h00, 5'h01, 1'b1}, // R5 no flip at 1
    '{4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 16'd59,  7'h59, 5'h01, 1'b1}, // R6
    '{4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'd60,  7'h00, 5'h02, 1'b1}, // R3 carry to hour
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b1, 16'd9,   7'h00, 5'h11, 1'b1}, // R6
    '{4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 16'd59,  7'h59, 5'h11, 1'b1}, // R6
    '{4'd9, 1'b0, 1'b1, 1'b0, 1'b0, 16'd59,  7'h59, 5'h11, 1'b1}, // R9 not yet
    '{4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1,   7'h00, 5'h12, 1'b0}, // R5 carry to 12
    '{4'd3, 1'b1, 1'b0, 1'b1, 1'b0, 16'd10,  7'h10, 5'h12, 1'b0}  // R3 9 -> 10
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sec_tick_i = 1'b0, set_mode_i = 1'b0, inc_m_i = 1'b0, inc_h_i = 1'b0;
  logic [6:0] min_bcd_o;
  logic [4:0] hr_bcd_o;
  logic       pm_o;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  clock12_time_ctr u0 (
    .clk_i, .rst_ni, .sec_tick_i, .set_mode_i, .inc_m_i, .inc_h_i,
    .min_bcd_o, .hr_bcd_o, .pm_o
  );

  task automatic check(input string tag, input logic [6:0] emin,
                       input logic [4:0] ehr, input logic epm);
    checks++;
    if (min_bcd_o !== emin || hr_bcd_o !== ehr || pm_o !== epm) begin
      failures++;
      $display("FAIL %s: got min=%h hr=%h pm=%b expected min=%h hr=%h pm=%b",
               tag, min_bcd_o, hr_bcd_o, pm_o, emin, ehr, epm);
    end
  endtask

  task automatic apply(input step_t s);
    @(negedge clk_i);
    set_mode_i = s.set;
    @(negedge clk_i);
    sec_tick_i = s.sec; inc_m_i = s.im; inc_h_i = s.ih;
    repeat (s.reps) @(negedge clk_i);
    sec_tick_i = 1'b0; inc_m_i = 1'b0; inc_h_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 7'h00, 5'h12, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 after release", 7'h00, 5'h12, 1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      apply(STEPS[i]);
      check($sformatf("R%0d step %0d", STEPS[i].req, i),
            STEPS[i].min, STEPS[i].hr, STEPS[i].pm);
    end

    // R9: single tick at 12:10:59 changes nothing until its edge
    set_mode_i = 1'b0;
    apply('{4'd9, 1'b0, 1'b1, 1'b0, 1'b0, 16'd59, 7'h10, 5'h12, 1'b0});
    check("R9 before edge", 7'h10, 5'h12, 1'b0);
    sec_tick_i = 1'b1;
    @(posedge clk_i); #1;
    check("R9 same edge", 7'h11, 5'h12, 1'b0);
    @(negedge clk_i); sec_tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9 stable", 7'h11, 5'h12, 1'b0);

    // R1: asynchronous reset mid-run
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1 check("R1 async", 7'h00, 5'h12, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    apply('{4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'd60, 7'h01, 5'h12, 1'b0});
    check("R2 after reset", 7'h01, 5'h12, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule